// File: doc/BRIEF.md
# Miss-Check Branch Redirect Unit

This unit sits next to the fetch stage of a simple in-order core and turns last-level-cache miss reports into a change of control flow. Before a loop runs, software fills a small table in which each entry pairs a trigger PC with a redirect target. While an Access phase issues its loads, every miss report tagged as coming from a monitored load sets a sticky miss flag.

When fetch presents a PC that matches a valid table entry, the unit evaluates the flag. If at least one monitored load missed, fetch is redirected to the entry's target. If none missed, fetch continues sequentially. An explicit check-miss instruction, signalled from decode with its own target, evaluates the flag in the same way. Every evaluation clears the flag, so each Access phase is judged only on its own loads. While the core runs on the alternative path (active context nonzero), no evaluation redirects.

Top module: `miss_redirect_unit`

## Requirements
- R1: After reset, `redirect_o` and `flush_o` are 0 and every table entry is invalid, so a fetch with a pending miss does not redirect.
- R2: When fetch presents a PC that matches a valid entry and a monitored miss is pending, `redirect_o` and `flush_o` are 1 in the next cycle and `redirect_pc_o` holds that entry's target.
- R3: When a matching PC is fetched and no monitored miss is pending, there is no redirect.
- R4: A miss report sets the flag only when `miss_mon` is 1. The flag then stays set over idle cycles until the next evaluation.
- R5: Each evaluation (a fetch that matches an entry, or a check-miss) clears the flag. A second evaluation with no new monitored miss falls through.
- R6: When a trigger PC matches more than one valid entry, the entry with the lowest index supplies the target.
- R7: Invalid entries never match. `tbl_clear_all` invalidates every entry, and it takes precedence over a table write in the same cycle.
- R8: A check-miss (`chk_valid`) follows the same miss rule and redirects to `chk_target`. If it occurs in the same cycle as a fetch trigger match, the check-miss target is used.
- R9: While `ctx_alt` is 1, an evaluation never redirects but still clears the flag.
- R10: `redirect_o` and `flush_o` are pulses of one cycle for each redirecting evaluation. Consecutive redirecting evaluations give consecutive pulses.
- R11: A monitored miss reported in the same cycle as an evaluation counts toward that evaluation.
- R12: A table write becomes visible to the PC compare in the cycle after the write. A fetch in the same cycle as the write compares against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(NUM_ENTRIES) | Entry index for the write |
| tbl_trig_pc | input | PC_W | Trigger PC to store |
| tbl_tgt_pc | input | PC_W | Redirect target to store |
| tbl_valid | input | 1 | Valid bit to store |
| tbl_clear_all | input | 1 | Invalidate all entries |
| miss_rpt | input | 1 | Last-level-cache miss report |
| miss_mon | input | 1 | Report comes from a monitored load |
| ctx_alt | input | 1 | Core is on the alternative path |
| fetch_valid | input | 1 | Fetch presents a PC this cycle |
| fetch_pc | input | PC_W | Fetch PC |
| chk_valid | input | 1 | Check-miss instruction evaluated |
| chk_target | input | PC_W | Target of the check-miss |
| redirect_o | output | 1 | Redirect fetch this cycle |
| redirect_pc_o | output | PC_W | PC to fetch next |
| flush_o | output | 1 | Flush pulse to fetch/decode registers |

## Verification
Every result of this unit appears exactly one cycle after the cycle whose inputs caused it: the table write, the miss flag and the redirect outputs are all single registers. The bench drives one cycle of stimulus at a falling edge and queues the expected outcome stamped with the cycle count in which it is due. The monitor compares the outputs at the following falling edge only when the stamp matches the current cycle, so each comparison lands one register stage after its stimulus. Cycles that must not redirect, such as fall-throughs, ignored reports, invalid entries and suppressed evaluations, get queued entries of their own, so a stray or stretched pulse is caught.

// File: rtl/miss_redirect_unit.sv
module miss_redirect_unit #(
  parameter int NUM_ENTRIES = 4,
  parameter int PC_W        = 32,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic [PC_W-1:0]  tbl_trig_pc,
  input  logic [PC_W-1:0]  tbl_tgt_pc,
  input  logic             tbl_valid,
  input  logic             tbl_clear_all,
  input  logic             miss_rpt,
  input  logic             miss_mon,
  input  logic             ctx_alt,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             chk_valid,
  input  logic [PC_W-1:0]  chk_target,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic             flush_o
);

  logic [PC_W-1:0]        trig_q [NUM_ENTRIES];
  logic [PC_W-1:0]        tgt_q  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] vld_q;
  logic                   acc_q;

  logic            hit_found;
  logic [PC_W-1:0] hit_tgt;

  always_comb begin
    hit_found = 1'b0;
    hit_tgt   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && trig_q[i] == fetch_pc) begin
        hit_found = 1'b1;
        hit_tgt   = tgt_q[i];
      end
    end
  end

  wire mon_miss = miss_rpt & miss_mon;
  wire eval     = chk_valid | (fetch_valid & hit_found);
  wire take     = eval & (acc_q | mon_miss) & ~ctx_alt;
  wire [PC_W-1:0] sel_tgt = chk_valid ? chk_target : hit_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        trig_q[i] <= '0;
        tgt_q[i]  <= '0;
      end
    end else if (tbl_clear_all) begin
      vld_q <= '0;
    end else if (tbl_we) begin
      vld_q[tbl_idx]  <= tbl_valid;
      trig_q[tbl_idx] <= tbl_trig_pc;
      tgt_q[tbl_idx]  <= tbl_tgt_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q         <= 1'b0;
      redirect_o    <= 1'b0;
      flush_o       <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      acc_q      <= eval ? 1'b0 : (acc_q | mon_miss);
      redirect_o <= take;
      flush_o    <= take;
      if (take) redirect_pc_o <= sel_tgt;
    end
  end

endmodule

// File: rtl/miss_redirect_unit_chk.sv
module miss_redirect_unit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic            chk_valid,
  input logic [PC_W-1:0] chk_target,
  input logic            miss_rpt,
  input logic            miss_mon,
  input logic            ctx_alt,
  input logic            acc_q,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o
);

  assert_redirect_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> ($past(fetch_valid) || $past(chk_valid)));

  assert_redirect_needs_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> ($past(acc_q) || $past(miss_rpt && miss_mon)));

  assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_rpt && miss_mon && !chk_valid && !fetch_valid) |=> acc_q);

  assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> !acc_q);

  assert_chk_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && $past(chk_valid)) |-> redirect_pc_o == $past(chk_target));

  assert_no_redirect_alt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> !$past(ctx_alt));

endmodule

bind miss_redirect_unit miss_redirect_unit_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .chk_valid(chk_valid),
  .chk_target(chk_target), .miss_rpt(miss_rpt), .miss_mon(miss_mon),
  .ctx_alt(ctx_alt), .acc_q(acc_q), .redirect_o(redirect_o),
  .redirect_pc_o(redirect_pc_o)
);

// File: tb/miss_redirect_unit_tb_top.sv
module miss_redirect_unit_tb_top;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tbl_we = 0, tbl_valid = 0, tbl_clear_all = 0;
  logic [1:0]      tbl_idx = '0;
  logic [PC_W-1:0] tbl_trig_pc = '0, tbl_tgt_pc = '0;
  logic            miss_rpt = 0, miss_mon = 0, ctx_alt = 0;
  logic            fetch_valid = 0, chk_valid = 0;
  logic [PC_W-1:0] fetch_pc = '0, chk_target = '0;
  logic            redirect_o, flush_o;
  logic [PC_W-1:0] redirect_pc_o;

  miss_redirect_unit #(.NUM_ENTRIES(4), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_trig_pc(tbl_trig_pc), .tbl_tgt_pc(tbl_tgt_pc), .tbl_valid(tbl_valid),
    .tbl_clear_all(tbl_clear_all), .miss_rpt(miss_rpt), .miss_mon(miss_mon),
    .ctx_alt(ctx_alt), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .chk_valid(chk_valid), .chk_target(chk_target), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .flush_o(flush_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int              due;
    logic            exp_r;
    logic [PC_W-1:0] exp_pc;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (redirect_o !== e.exp_r || flush_o !== e.exp_r ||
          (e.exp_r && redirect_pc_o !== e.exp_pc)) begin
        errors++;
        $display("FAIL %s: redirect=%0b flush=%0b pc=%h expected redirect=%0b pc=%h",
                 e.tag, redirect_o, flush_o, redirect_pc_o, e.exp_r, e.exp_pc);
      end
    end
  end

  task automatic tick(input logic er, input logic [PC_W-1:0] epc, input string tag);
    exp_t e;
    e.due = cyc + 1; e.exp_r = er; e.exp_pc = epc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    tbl_we = 0; tbl_clear_all = 0; miss_rpt = 0; miss_mon = 0;
    fetch_valid = 0; chk_valid = 0; ctx_alt = 0;
  endtask

  task automatic wr(input int idx, input logic [PC_W-1:0] trig, input logic [PC_W-1:0] tgt,
                    input logic v);
    tbl_we = 1; tbl_idx = idx[1:0]; tbl_trig_pc = trig; tbl_tgt_pc = tgt; tbl_valid = v;
  endtask

  task automatic fetch(input logic [PC_W-1:0] pc);
    fetch_valid = 1; fetch_pc = pc;
  endtask

  task automatic mmiss(input logic mon);
    miss_rpt = 1; miss_mon = mon;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (redirect_o !== 1'b0 || flush_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: redirect=%0b flush=%0b expected 0 0", redirect_o, flush_o);
    end
    rst_n = 1;
    @(negedge clk);
    mmiss(1); tick(0, 0, "R1 flag set, no entries");
    fetch(32'h100); tick(0, 0, "R1 empty table no match");
    mmiss(1); tick(0, 0, "flag set");
    wr(1, 32'h200, 32'h900, 1); tick(0, 0, "write e1");
    wr(2, 32'h100, 32'hA00, 1); tick(0, 0, "write e2");
    wr(3, 32'h300, 32'hB00, 0); tick(0, 0, "write e3 invalid");
    wr(0, 32'h100, 32'h800, 1); tick(0, 0, "write e0");
    fetch(32'h100); tick(1, 32'h800, "R2 R6 R12 lowest entry wins");
    fetch(32'h100); tick(0, 0, "R5 flag cleared falls through");
    mmiss(0); tick(0, 0, "R4 unmonitored report");
    fetch(32'h200); tick(0, 0, "R4 unmonitored ignored");
    mmiss(1); tick(0, 0, "R4 monitored report");
    tick(0, 0, "idle");
    tick(0, 0, "idle");
    fetch(32'h200); tick(1, 32'h900, "R4 sticky flag redirect");
    tick(0, 0, "R10 pulse ends");
    fetch(32'h200); mmiss(1); tick(1, 32'h900, "R11 same-cycle miss");
    fetch(32'h100); mmiss(1); tick(1, 32'h800, "R10 back-to-back pulse");
    fetch(32'h200); tick(0, 0, "R3 no miss fall-through");
    fetch(32'h300); mmiss(1); tick(0, 0, "R7 invalid entry no match");
    fetch(32'h500); tick(0, 0, "no entry");
    chk_valid = 1; chk_target = 32'hC00; tick(1, 32'hC00, "R8 check-miss redirect");
    chk_valid = 1; chk_target = 32'hC00; tick(0, 0, "R8 check-miss no miss");
    mmiss(1); tick(0, 0, "flag set");
    chk_valid = 1; chk_target = 32'hC04; fetch(32'h100); tick(1, 32'hC04, "R8 check-miss priority");
    fetch(32'h100); tick(0, 0, "R5 both cleared");
    mmiss(1); tick(0, 0, "flag set");
    ctx_alt = 1; fetch(32'h100); tick(0, 0, "R9 suppressed on alt path");
    fetch(32'h100); tick(0, 0, "R9 flag cleared by suppressed eval");
    ctx_alt = 1; chk_valid = 1; chk_target = 32'hC08; mmiss(1); tick(0, 0, "R9 check-miss suppressed");
    tbl_clear_all = 1; wr(0, 32'h400, 32'hD00, 1); tick(0, 0, "clear with write");
    mmiss(1); tick(0, 0, "flag set");
    fetch(32'h400); tick(0, 0, "R7 clear beats write");
    fetch(32'h200); mmiss(1); tick(0, 0, "R7 clear invalidated e1");
    wr(1, 32'h600, 32'hE00, 1); tick(0, 0, "rewrite e1");
    fetch(32'h600); tick(1, 32'hE00, "R2 R12 new entry redirect");
    tick(0, 0, "R10 idle");
    @(negedge clk);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule